// File: doc/BRIEF.md
# Indexed Bit and Shift Unit

This block is the execute stage for the indexed bit-manipulation group of an 8-bit processor core with 16-bit index registers. The sequencer hands it the index register value, the signed displacement byte (fetched before the operation byte), the operation byte, the byte already read from memory at the target address, and the current flag register. One clock later the block returns the target address, the result byte, the new flags, and the write controls.

The operation byte is split into three fields. Bits 7:6 pick the group: rotate/shift, bit test, bit clear or bit set. Bits 5:3 pick the shift kind or the bit number. Bits 2:0 would normally name the operand. In this group the operand is always the memory byte, so bits 2:0 instead name a register that also receives the result. The block also reports the instruction length in clock cycles, and marks the undocumented forms so that the core can trace them. Bus sequencing, prefix decode and the refresh counter are handled elsewhere. This unit never asks for a refresh step.

Top module: `xbs_unit`

## Requirements
- R1: While reset is held and afterwards with no request, `done`, `mem_we` and `reg_we` are 0; a request on `start` gives `done`=1 on the very next clock edge, for one cycle only.
- R2: `addr` equals `idx_base` plus `disp` sign-extended to the address width, wrapping modulo 2^ADDR_W.
- R3: Group 0 (op[7:6]=00) shifts the byte per op[5:3]: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 arithmetic left (0 in), 5 arithmetic right (bit 7 kept), 6 left with 1 shifted in, 7 logical right (0 in); carry in is flags_in[0].
- R4: After a shift the flags (bit 7..0 = S Z Y H X P N C) are: S = result bit 7, Z = result is zero, Y/X = result bits 5/3, H = N = 0, P = 1 when the result has an even number of ones, C = the bit shifted out.
- R5: Group 2 (10) clears and group 3 (11) sets bit op[5:3] of the byte; flags_out equals flags_in.
- R6: Group 1 (01) tests bit op[5:3]: Z = P = inverse of that bit, H = 1, N = 0, S = 1 only for bit 7 when it is 1, C = flags_in[0], Y/X = addr bits 13/11; `result` is the unchanged byte.
- R7: A bit test writes neither memory nor a register, whatever op[2:0] holds.
- R8: For groups 0, 2 and 3, `mem_we` = 1; if op[2:0] is not 6, `reg_we` = 1 and `reg_sel` = op[2:0] (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A); with op[2:0] = 6 `reg_we` = 0.
- R9: `undoc` = 1 when op[2:0] is not 6 (any group), and also for the left shift with 1 in (group 0, op[5:3]=6) in its memory-only form.
- R10: `tcycles` is 20 for a bit test and 23 for every other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request: the inputs below are valid this cycle |
| idx_base | input | ADDR_W | Index register value |
| disp | input | 8 | Signed displacement |
| op | input | 8 | Operation byte |
| rd_data | input | 8 | Byte read from the target address |
| flags_in | input | 8 | Current flag register |
| done | output | 1 | Results valid, one cycle |
| addr | output | ADDR_W | Target address |
| result | output | 8 | Result byte |
| flags_out | output | 8 | New flag register |
| mem_we | output | 1 | Write result back to addr |
| reg_we | output | 1 | Also copy result to a register |
| reg_sel | output | 3 | Register code for the copy |
| undoc | output | 1 | Undocumented form executed |
| tcycles | output | CYC_W | Instruction length in clock cycles |

## Verification
The bench goes after the carry-through rotates with both carry values, since a design that ignored flags_in[0] would produce a wrong bit 0 or bit 7. It covers negative displacements that wrap below address zero, where a zero-extending adder would point above the index instead. It uses bit tests with register codes, where a design that shared the write decode with the other groups would corrupt memory or a register. It also checks the memory-only left shift with 1 in, where a design that keyed the undocumented flag only on op[2:0] would stay silent. Random operation bytes cover the parity and sign flags on every shift kind.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int DATA_W = 8;

    // flag register bit positions
    localparam int FB_C = 0;
    localparam int FB_N = 1;
    localparam int FB_P = 2;
    localparam int FB_X = 3;
    localparam int FB_H = 4;
    localparam int FB_Y = 5;
    localparam int FB_Z = 6;
    localparam int FB_S = 7;

    localparam logic [2:0] MEM_CODE = 3'd6;
    localparam logic [2:0] SHL1_KIND = 3'd6;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_ROLC = 3'd0,
        SH_RORC = 3'd1,
        SH_ROL  = 3'd2,
        SH_ROR  = 3'd3,
        SH_ASL  = 3'd4,
        SH_ASR  = 3'd5,
        SH_SL1  = 3'd6,
        SH_LSR  = 3'd7
    } shk_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cout;
    } shout_s;

    function automatic logic even_par(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/xbs_agen.sv
module xbs_agen #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [7:0]        disp,
    output logic [ADDR_W-1:0] tgt
);
    localparam int EXT_W = ADDR_W - 8;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[7]}}, disp};
        tgt      = base + disp_ext;
    end
endmodule

// File: rtl/xbs_alu.sv
module xbs_alu
    import xbs_pkg::*;
(
    input  logic [7:0]        op,
    input  logic [DATA_W-1:0] val,
    input  logic [7:0]        flg_in,
    input  logic [7:0]        addr_hi,
    output logic [DATA_W-1:0] res,
    output logic [7:0]        flg
);
    grp_e              grp;
    logic [2:0]        sel;
    logic [DATA_W-1:0] mask;
    shout_s            sh;
    logic              tbit;

    // one-hot bit mask for the tested / changed bit
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_mask
            assign mask[gi] = (sel == gi[2:0]);
        end
    endgenerate

    always_comb begin
        grp = grp_e'(op[7:6]);
        sel = op[5:3];
    end

    // shifter
    always_comb begin
        sh = '0;
        unique case (shk_e'(sel))
            SH_ROLC: sh = '{res: {val[6:0], val[7]},    cout: val[7]};
            SH_RORC: sh = '{res: {val[0], val[7:1]},    cout: val[0]};
            SH_ROL:  sh = '{res: {val[6:0], flg_in[FB_C]}, cout: val[7]};
            SH_ROR:  sh = '{res: {flg_in[FB_C], val[7:1]}, cout: val[0]};
            SH_ASL:  sh = '{res: {val[6:0], 1'b0},      cout: val[7]};
            SH_ASR:  sh = '{res: {val[7], val[7:1]},    cout: val[0]};
            SH_SL1:  sh = '{res: {val[6:0], 1'b1},      cout: val[7]};
            SH_LSR:  sh = '{res: {1'b0, val[7:1]},      cout: val[0]};
            default: sh = '0;
        endcase
    end

    always_comb begin
        tbit = |(val & mask);
        res  = val;
        flg  = flg_in;
        unique case (grp)
            GRP_SHIFT: begin
                res        = sh.res;
                flg[FB_S]  = sh.res[7];
                flg[FB_Z]  = (sh.res == '0);
                flg[FB_Y]  = sh.res[5];
                flg[FB_H]  = 1'b0;
                flg[FB_X]  = sh.res[3];
                flg[FB_P]  = even_par(sh.res);
                flg[FB_N]  = 1'b0;
                flg[FB_C]  = sh.cout;
            end
            GRP_TEST: begin
                res        = val;
                flg[FB_S]  = tbit & (sel == 3'd7);
                flg[FB_Z]  = ~tbit;
                flg[FB_Y]  = addr_hi[5];
                flg[FB_H]  = 1'b1;
                flg[FB_X]  = addr_hi[3];
                flg[FB_P]  = ~tbit;
                flg[FB_N]  = 1'b0;
                flg[FB_C]  = flg_in[FB_C];
            end
            GRP_CLR: res = val & ~mask;
            GRP_SET: res = val | mask;
            default: res = val;
        endcase
    end
endmodule

// File: rtl/xbs_dest.sv
module xbs_dest
    import xbs_pkg::*;
#(
    parameter int TEST_CYC = 20,
    parameter int RMW_CYC  = 23,
    parameter int CYC_W    = 5
) (
    input  logic [7:0]       op,
    output logic             mem_we,
    output logic             reg_we,
    output logic [2:0]       reg_sel,
    output logic             undoc,
    output logic [CYC_W-1:0] cyc
);
    logic is_test;
    logic is_mem;
    logic is_sl1;

    always_comb begin
        is_test = (grp_e'(op[7:6]) == GRP_TEST);
        is_mem  = (op[2:0] == MEM_CODE);
        is_sl1  = (grp_e'(op[7:6]) == GRP_SHIFT) && (op[5:3] == SHL1_KIND);
        mem_we  = ~is_test;
        reg_we  = ~is_test & ~is_mem;
        reg_sel = op[2:0];
        undoc   = ~is_mem | is_sl1;
        cyc     = is_test ? CYC_W'(TEST_CYC) : CYC_W'(RMW_CYC);
    end
endmodule

// File: rtl/xbs_unit.sv
module xbs_unit
    import xbs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int TEST_CYC = 20,
    parameter int RMW_CYC  = 23,
    parameter int CYC_W    = $clog2(RMW_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] idx_base,
    input  logic [7:0]        disp,
    input  logic [7:0]        op,
    input  logic [7:0]        rd_data,
    input  logic [7:0]        flags_in,
    output logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        result,
    output logic [7:0]        flags_out,
    output logic              mem_we,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic              undoc,
    output logic [CYC_W-1:0]  tcycles
);
    typedef struct packed {
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        res;
        logic [7:0]        flg;
        logic              mem_we;
        logic              reg_we;
        logic [2:0]        reg_sel;
        logic              undoc;
        logic [CYC_W-1:0]  cyc;
    } st_s;

    st_s st_d, st_q;

    logic [ADDR_W-1:0] tgt;
    logic [7:0]        alu_res;
    logic [7:0]        alu_flg;
    logic              dec_mem_we;
    logic              dec_reg_we;
    logic [2:0]        dec_reg_sel;
    logic              dec_undoc;
    logic [CYC_W-1:0]  dec_cyc;

    xbs_agen #(.ADDR_W(ADDR_W)) u_agen (
        .base (idx_base),
        .disp (disp),
        .tgt  (tgt)
    );

    xbs_alu u_alu (
        .op      (op),
        .val     (rd_data),
        .flg_in  (flags_in),
        .addr_hi (tgt[ADDR_W-1 -: 8]),
        .res     (alu_res),
        .flg     (alu_flg)
    );

    xbs_dest #(
        .TEST_CYC (TEST_CYC),
        .RMW_CYC  (RMW_CYC),
        .CYC_W    (CYC_W)
    ) u_dest (
        .op      (op),
        .mem_we  (dec_mem_we),
        .reg_we  (dec_reg_we),
        .reg_sel (dec_reg_sel),
        .undoc   (dec_undoc),
        .cyc     (dec_cyc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.mem_we = 1'b0;
        st_d.reg_we = 1'b0;
        if (start) begin
            st_d.done    = 1'b1;
            st_d.addr    = tgt;
            st_d.res     = alu_res;
            st_d.flg     = alu_flg;
            st_d.mem_we  = dec_mem_we;
            st_d.reg_we  = dec_reg_we;
            st_d.reg_sel = dec_reg_sel;
            st_d.undoc   = dec_undoc;
            st_d.cyc     = dec_cyc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign addr      = st_q.addr;
    assign result    = st_q.res;
    assign flags_out = st_q.flg;
    assign mem_we    = st_q.mem_we;
    assign reg_we    = st_q.reg_we;
    assign reg_sel   = st_q.reg_sel;
    assign undoc     = st_q.undoc;
    assign tcycles   = st_q.cyc;
endmodule

// File: rtl/xbs_unit_chk.sv
module xbs_unit_chk #(
    parameter int ADDR_W   = 16,
    parameter int TEST_CYC = 20,
    parameter int RMW_CYC  = 23,
    parameter int CYC_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] idx_base,
    input logic [7:0]        disp,
    input logic [7:0]        op,
    input logic [7:0]        flags_in,
    input logic              done,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        flags_out,
    input logic              mem_we,
    input logic              reg_we,
    input logic [CYC_W-1:0]  tcycles
);
    a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done && !mem_we && !reg_we);

    a_r2_target: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> addr == $past(idx_base + {{(ADDR_W-8){disp[7]}}, disp}));

    a_r5_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[7]) |=> flags_out == $past(flags_in));

    a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[7:6] == 2'b01) |=> !mem_we && !reg_we);

    a_r8_copy_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> mem_we);

    a_r10_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tcycles == CYC_W'(TEST_CYC) || tcycles == CYC_W'(RMW_CYC)));
endmodule

bind xbs_unit xbs_unit_chk #(
    .ADDR_W   (ADDR_W),
    .TEST_CYC (TEST_CYC),
    .RMW_CYC  (RMW_CYC),
    .CYC_W    (CYC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .idx_base  (idx_base),
    .disp      (disp),
    .op        (op),
    .flags_in  (flags_in),
    .done      (done),
    .addr      (addr),
    .flags_out (flags_out),
    .mem_we    (mem_we),
    .reg_we    (reg_we),
    .tcycles   (tcycles)
);

// File: tb/xbs_unit_test.sv
module xbs_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] idx_base = '0;
    logic [7:0]    disp = '0, op = '0, rd_data = '0, flags_in = '0;
    logic          done, mem_we, reg_we, undoc;
    logic [AW-1:0] addr;
    logic [7:0]    result, flags_out;
    logic [2:0]    reg_sel;
    logic [CW-1:0] tcycles;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbs_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_base(idx_base),
        .disp(disp), .op(op), .rd_data(rd_data), .flags_in(flags_in),
        .done(done), .addr(addr), .result(result), .flags_out(flags_out),
        .mem_we(mem_we), .reg_we(reg_we), .reg_sel(reg_sel),
        .undoc(undoc), .tcycles(tcycles)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_res(input logic [7:0] o, input logic [7:0] v,
                                           input logic ci, output logic co);
        logic [2:0] n = o[5:3];
        co = 1'b0;
        case (o[7:6])
            2'b00: case (n)
                3'd0: begin co = v[7]; return (v << 1) | (v >> 7); end
                3'd1: begin co = v[0]; return (v >> 1) | (v << 7); end
                3'd2: begin co = v[7]; return (v << 1) | {7'd0, ci}; end
                3'd3: begin co = v[0]; return (v >> 1) | {ci, 7'd0}; end
                3'd4: begin co = v[7]; return v << 1; end
                3'd5: begin co = v[0]; return (v >> 1) | (v & 8'h80); end
                3'd6: begin co = v[7]; return (v << 1) | 8'h01; end
                default: begin co = v[0]; return v >> 1; end
            endcase
            2'b10: return v & ~(8'h01 << n);
            2'b11: return v | (8'h01 << n);
            default: return v;
        endcase
    endfunction

    task automatic run(input logic [AW-1:0] b, input logic [7:0] d, input logic [7:0] o,
                       input logic [7:0] v, input logic [7:0] f);
        logic [AW-1:0] ea;
        logic [7:0] er, ef;
        logic co, bt, memf;
        @(negedge clk);
        idx_base = b; disp = d; op = o; rd_data = v; flags_in = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ea = b + AW'($signed(d));
        er = exp_res(o, v, f[0], co);
        memf = (o[2:0] == 3'd6);
        chk("R1", "done", done, 1);
        chk("R2", "addr", addr, ea);
        chk("R10", "tcycles", tcycles, (o[7:6] == 2'b01) ? 20 : 23);
        chk("R9", "undoc", undoc, (!memf || (o[7:6] == 2'b00 && o[5:3] == 3'd6)) ? 1 : 0);
        if (o[7:6] == 2'b01) begin
            bt = v[o[5:3]];
            ef = {(o[5:3] == 3'd7) & bt, ~bt, ea[13], 1'b1, ea[11], ~bt, 1'b0, f[0]};
            chk("R6", "result", result, v);
            chk("R6", "flags", flags_out, ef);
            chk("R7", "mem_we", mem_we, 0);
            chk("R7", "reg_we", reg_we, 0);
        end else begin
            chk("R8", "mem_we", mem_we, 1);
            chk("R8", "reg_we", reg_we, memf ? 0 : 1);
            if (!memf) chk("R8", "reg_sel", reg_sel, o[2:0]);
            if (o[7:6] == 2'b00) begin
                ef = {er[7], er == 8'h00, er[5], 1'b0, er[3], ~(^er), 1'b0, co};
                chk("R3", "result", result, er);
                chk("R4", "flags", flags_out, ef);
            end else begin
                chk("R5", "result", result, er);
                chk("R5", "flags", flags_out, f);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", done, 0);
        chk("R1", "mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "done idle", done, 0);
        chk("R1", "reg_we idle", reg_we, 0);

        // directed corners
        run(16'h0005, 8'hF0, 8'b01_111_110, 8'h80, 8'h00); // R6 bit 7 set, wrap below zero (R2)
        run(16'h2800, 8'h7F, 8'b01_000_110, 8'hFE, 8'h01); // R6 bit 0 clear, C kept
        run(16'h1000, 8'h00, 8'b01_011_111, 8'h08, 8'h00); // R7 bit test with register code
        run(16'h4000, 8'h01, 8'b00_010_110, 8'h80, 8'h01); // R3 rotate through carry, carry 1
        run(16'h4000, 8'h01, 8'b00_011_000, 8'h01, 8'h00); // R3 rotate right through carry, carry 0
        run(16'h4000, 8'hFF, 8'b00_101_111, 8'h81, 8'h00); // R3 arithmetic right, copy to A
        run(16'h4000, 8'h02, 8'b00_110_110, 8'h00, 8'h00); // R9 left with 1 in, memory form
        run(16'h4000, 8'h02, 8'b00_111_110, 8'h01, 8'h00); // R4 result zero, carry out
        run(16'hFFFF, 8'h01, 8'b11_011_111, 8'h00, 8'hA5); // R5 set bit 3 into A, wrap up
        run(16'h0100, 8'h80, 8'b10_111_100, 8'hFF, 8'h5A); // R5 clear bit 7 into H
        run(16'h0100, 8'h80, 8'b10_000_110, 8'hFF, 8'h00); // R8 memory only

        @(negedge clk);
        chk("R1", "done after one request", done, 0);
        chk("R1", "mem_we after one request", mem_we, 0);

        for (int i = 0; i < 400; i++) begin
            run(AW'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule